// File: doc/BRIEF.md
# Memory Low-Power State Manager

This block is the power-state controller of a packet-based DRAM device. It holds the device in one of two active states, standby or attention, or in one of the low-power states, nap and power-down. Each low-power state also has an "A" variant, chosen when the state is entered. Entry commands arrive as single-cycle pulses from the packet decoder. Exit requests arrive serially on a command line. Everything runs on the serial clock.

An exit frame has three parts. It opens with a start bit. A code bit follows that names the state being left. In addressed mode a device identifier follows, taken from the serial data input. A chain output repeats the serial data input one cycle later, so that devices can be chained. A configuration bit turns on broadcast mode. In broadcast mode every device accepts the frame and no identifier is read. Another configuration bit selects the device-selection slot. When this slot bit is 1, one idle cycle is inserted before the identifier or the decision. This device is expected to run with the slot bit set to 1.

An accepted exit starts a programmable exit delay. The delay is counted in nap units for nap and in units of 256 cycles for power-down. While the delay runs, row packets are blocked. Column packets are blocked as well when the state being left is an A variant. At the end of the delay the block returns to attention if the relax input was high when the low-power state was entered, and to standby otherwise. After any entry, a fixed lockout window rejects exit frames.

Top module: `lp_state_mgr`

## Requirements
- R1: After reset, `pwr_state` is 0 (standby), and `row_block`, `col_block` and `sio_out` are all 0.
- R2: In standby (0) or attention (1), a pulse on `pdn_enter` moves the state at the next edge to power-down (3), or to power-down-A (5) if `enter_sub_a` is high. Otherwise a pulse on `nap_enter` moves it to nap (2), or to nap-A (4). `pdn_enter` wins when both pulses are high. `relax_in` is captured in the same cycle.
- R3: An entry pulse that arrives in any state other than standby or attention has no effect. This includes the `relax_in` value that comes with it.
- R4: An exit frame starts with `cmd`=1 sampled at edge k, at a time when the block is in a low-power state and outside the lockout window. The code bit follows on `cmd` at edge k+1, with 0 meaning nap exit and 1 meaning power-down exit. If `cfg_slot`=1, one idle cycle follows. Then, unless the frame is broadcast, 6 identifier bits are read from `sio_in`, most significant bit first. The state becomes exit-pending (6) at the edge after the last frame bit.
- R5: An addressed frame whose identifier differs from `dev_id` is ignored. When `cfg_bcast`=1 the frame is accepted whatever `sio_in` carries.
- R6: A frame whose code bit does not match the current low-power kind is ignored, and the state does not change.
- R7: The exit-pending state lasts D+1 cycles. D is `cfg_nap_dly` for a nap exit and 256×`cfg_pdn_dly` for a power-down exit.
- R8: When the exit delay ends, the state becomes attention (1) if `relax_in` was high at entry, and standby (0) otherwise.
- R9: `row_block` is high exactly while the state is exit-pending. `col_block` is high only at those times, and only when the state being left is nap-A or power-down-A.
- R10: For LOCKOUT (23) cycles after an entry at edge e, start bits are ignored. The earliest start bit that is accepted is the one sampled at edge e+24.
- R11: `sio_out` equals the value `sio_in` had one clock earlier.
- R12: A start bit on `cmd` is ignored while the state is standby or attention. This also holds when the start bit arrives in the same cycle as an entry pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all state advances on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| nap_enter | input | 1 | Nap entry command pulse |
| pdn_enter | input | 1 | Power-down entry command pulse |
| enter_sub_a | input | 1 | Entry goes to the A variant of the low-power state |
| relax_in | input | 1 | Relax flag, captured at entry; selects the return state |
| cmd | input | 1 | Serial command line carrying the exit start bit and code bit |
| sio_in | input | 1 | Serial data input carrying the device identifier |
| sio_out | output | 1 | Serial data input repeated one cycle later |
| cfg_bcast | input | 1 | 1: exit frames are broadcast and carry no identifier |
| cfg_slot | input | 1 | Device-selection slot; 1 inserts one idle cycle after the code bit |
| cfg_nap_dly | input | 5 | Nap exit delay, in cycles |
| cfg_pdn_dly | input | 6 | Power-down exit delay, in units of 256 cycles |
| dev_id | input | 6 | Local device identifier |
| pwr_state | output | 3 | Current state: 0 standby, 1 attention, 2 nap, 3 power-down, 4 nap-A, 5 power-down-A, 6 exit-pending |
| row_block | output | 1 | Row packets must not be accepted |
| col_block | output | 1 | Column packets must not be accepted |

## Verification
An entry pulse and an exit start bit can be sampled at the same edge. The receiver must then judge the start bit against the old, active state, so no frame may begin. The bench provokes this by raising `nap_enter` and `cmd` together while the block is in attention. It then checks that the state sits in nap for the following frame length rather than moving to exit-pending. In a second case, a start bit lands on the last lockout cycle and another lands on the first free cycle. The bench checks that only the second of these is honoured.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        PS_STBY   = 3'd0,
        PS_ATTN   = 3'd1,
        PS_NAP    = 3'd2,
        PS_PDN    = 3'd3,
        PS_NAP_A  = 3'd4,
        PS_PDN_A  = 3'd5,
        PS_EXIT   = 3'd6
    } pstate_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_CODE,
        RX_GAP,
        RX_ID,
        RX_DECIDE
    } rx_e;

    typedef struct packed {
        logic valid;
        logic code;   // 0: nap exit, 1: power-down exit
    } exit_req_t;

    function automatic logic is_active(logic [2:0] s);
        return (s == PS_STBY) || (s == PS_ATTN);
    endfunction

    function automatic logic is_low(logic [2:0] s);
        return (s == PS_NAP) || (s == PS_PDN) || (s == PS_NAP_A) || (s == PS_PDN_A);
    endfunction

    function automatic logic is_sub_a(logic [2:0] s);
        return (s == PS_NAP_A) || (s == PS_PDN_A);
    endfunction

    function automatic logic code_fits(logic [2:0] s, logic code);
        if (code)
            return (s == PS_PDN) || (s == PS_PDN_A);
        return (s == PS_NAP) || (s == PS_NAP_A);
    endfunction

endpackage

// File: rtl/lpm_countdown.sv
module lpm_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] value,
    output logic         zero
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= value;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/lpm_exit_rx.sv
module lpm_exit_rx
    import lpm_pkg::*;
#(
    parameter int ID_W = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            armed,
    input  logic            cmd,
    input  logic            sio_in,
    input  logic            cfg_bcast,
    input  logic            cfg_slot,
    input  logic [ID_W-1:0] dev_id,
    output exit_req_t       req,
    output logic            sio_out
);
    localparam int CW = $clog2(ID_W + 1);

    rx_e             st;
    logic            code_q;
    logic [ID_W-1:0] shreg;
    logic [CW-1:0]   bitcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= RX_IDLE;
            code_q  <= 1'b0;
            shreg   <= '0;
            bitcnt  <= '0;
            sio_out <= 1'b0;
        end else begin
            sio_out <= sio_in;
            case (st)
                RX_IDLE: begin
                    if (armed && cmd)
                        st <= RX_CODE;
                end
                RX_CODE: begin
                    code_q <= cmd;
                    bitcnt <= '0;
                    if (cfg_slot)
                        st <= RX_GAP;
                    else if (cfg_bcast)
                        st <= RX_DECIDE;
                    else
                        st <= RX_ID;
                end
                RX_GAP: begin
                    st <= cfg_bcast ? RX_DECIDE : RX_ID;
                end
                RX_ID: begin
                    shreg  <= {shreg[ID_W-2:0], sio_in};
                    bitcnt <= bitcnt + 1'b1;
                    if (bitcnt == CW'(ID_W - 1))
                        st <= RX_DECIDE;
                end
                RX_DECIDE: st <= RX_IDLE;
                default:   st <= RX_IDLE;
            endcase
        end
    end

    always_comb begin
        req.valid = (st == RX_DECIDE) && (cfg_bcast || (shreg == dev_id));
        req.code  = code_q;
    end
endmodule

// File: rtl/lp_state_mgr.sv
module lp_state_mgr
    import lpm_pkg::*;
#(
    parameter int ID_W      = 6,
    parameter int NAPX_W    = 5,
    parameter int PDNX_W    = 6,
    parameter int PDN_SCALE = 256,
    parameter int LOCKOUT   = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              nap_enter,
    input  logic              pdn_enter,
    input  logic              enter_sub_a,
    input  logic              relax_in,
    input  logic              cmd,
    input  logic              sio_in,
    output logic              sio_out,
    input  logic              cfg_bcast,
    input  logic              cfg_slot,
    input  logic [NAPX_W-1:0] cfg_nap_dly,
    input  logic [PDNX_W-1:0] cfg_pdn_dly,
    input  logic [ID_W-1:0]   dev_id,
    output logic [2:0]        pwr_state,
    output logic              row_block,
    output logic              col_block
);
    localparam int SCALE_W = $clog2(PDN_SCALE + 1);
    localparam int EXIT_W  = (PDNX_W + SCALE_W > NAPX_W) ? PDNX_W + SCALE_W : NAPX_W;
    localparam int LOCK_W  = $clog2(LOCKOUT + 1);

    pstate_e     state, nxt;
    logic        relax_q, from_a_q;
    logic        lock_zero, exit_zero;
    logic        entry_go, exit_go;
    logic [EXIT_W-1:0] exit_len;
    exit_req_t   req;

    lpm_exit_rx #(.ID_W(ID_W)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .armed     (is_low(state) && lock_zero),
        .cmd       (cmd),
        .sio_in    (sio_in),
        .cfg_bcast (cfg_bcast),
        .cfg_slot  (cfg_slot),
        .dev_id    (dev_id),
        .req       (req),
        .sio_out   (sio_out)
    );

    lpm_countdown #(.W(LOCK_W)) u_lock (
        .clk   (clk),
        .rst   (rst),
        .load  (entry_go),
        .value (LOCK_W'(LOCKOUT)),
        .zero  (lock_zero)
    );

    lpm_countdown #(.W(EXIT_W)) u_exit (
        .clk   (clk),
        .rst   (rst),
        .load  (exit_go),
        .value (exit_len),
        .zero  (exit_zero)
    );

    always_comb begin
        entry_go = is_active(state) && (nap_enter || pdn_enter);
        exit_go  = req.valid && lock_zero && code_fits(state, req.code);
        exit_len = req.code ? EXIT_W'(cfg_pdn_dly) * EXIT_W'(PDN_SCALE)
                            : EXIT_W'(cfg_nap_dly);
    end

    always_comb begin
        nxt = state;
        case (state)
            PS_STBY, PS_ATTN: begin
                if (pdn_enter)
                    nxt = enter_sub_a ? PS_PDN_A : PS_PDN;
                else if (nap_enter)
                    nxt = enter_sub_a ? PS_NAP_A : PS_NAP;
            end
            PS_NAP, PS_NAP_A, PS_PDN, PS_PDN_A: begin
                if (exit_go)
                    nxt = PS_EXIT;
            end
            PS_EXIT: begin
                if (exit_zero)
                    nxt = relax_q ? PS_ATTN : PS_STBY;
            end
            default: nxt = PS_STBY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PS_STBY;
            relax_q  <= 1'b0;
            from_a_q <= 1'b0;
        end else begin
            state <= nxt;
            if (entry_go)
                relax_q <= relax_in;
            if (exit_go)
                from_a_q <= is_sub_a(state);
        end
    end

    assign pwr_state = state;
    assign row_block = (state == PS_EXIT);
    assign col_block = (state == PS_EXIT) && from_a_q;
endmodule

// File: rtl/lpm_chk.sv
module lpm_chk
    import lpm_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       nap_enter,
    input logic       pdn_enter,
    input logic       sio_in,
    input logic       sio_out,
    input logic [2:0] pwr_state,
    input logic       row_block,
    input logic       col_block
);
    // R9: column blocking never appears without row blocking
    assert_col_in_row_R9: assert property (@(posedge clk) disable iff (rst)
        col_block |-> row_block);

    // R9: blocking can only start right after a low-power state
    assert_row_rise_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(row_block) |-> is_low($past(pwr_state)));

    // R11: chain output repeats the serial input one cycle later
    assert_daisy_R11: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sio_out == $past(sio_in)));

    // R2: an active-to-low-power move needs an entry pulse
    assert_entry_cause_R2: assert property (@(posedge clk) disable iff (rst)
        (is_low(pwr_state) && is_active($past(pwr_state))) |-> $past(nap_enter || pdn_enter));

    // R6: a low-power state either holds or moves to exit-pending
    assert_low_hold_R6: assert property (@(posedge clk) disable iff (rst)
        is_low(pwr_state) |=> ((pwr_state == $past(pwr_state)) || (pwr_state == PS_EXIT)));

    // R8: leaving exit-pending always lands in an active state
    assert_exit_target_R8: assert property (@(posedge clk) disable iff (rst)
        (($past(pwr_state) == PS_EXIT) && (pwr_state != PS_EXIT)) |-> is_active(pwr_state));
endmodule

bind lp_state_mgr lpm_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .nap_enter (nap_enter),
    .pdn_enter (pdn_enter),
    .sio_in    (sio_in),
    .sio_out   (sio_out),
    .pwr_state (pwr_state),
    .row_block (row_block),
    .col_block (col_block)
);

// File: tb/sim_lp_state_mgr.sv
`timescale 1ns/1ps
module sim_lp_state_mgr;
    localparam int LOCK = 23;
    localparam logic [5:0] MY_ID = 6'h2B;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nap_enter = 1'b0, pdn_enter = 1'b0, enter_sub_a = 1'b0, relax_in = 1'b0;
    logic cmd = 1'b0, sio_in = 1'b0, sio_out;
    logic cfg_bcast = 1'b0, cfg_slot = 1'b1;
    logic [4:0] cfg_nap_dly = 5'd3;
    logic [5:0] cfg_pdn_dly = 6'd2;
    logic [5:0] dev_id = MY_ID;
    logic [2:0] pwr_state;
    logic row_block, col_block;

    int cyc = 0;
    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lp_state_mgr u0 (
        .clk(clk), .rst(rst), .nap_enter(nap_enter), .pdn_enter(pdn_enter),
        .enter_sub_a(enter_sub_a), .relax_in(relax_in), .cmd(cmd), .sio_in(sio_in),
        .sio_out(sio_out), .cfg_bcast(cfg_bcast), .cfg_slot(cfg_slot),
        .cfg_nap_dly(cfg_nap_dly), .cfg_pdn_dly(cfg_pdn_dly), .dev_id(dev_id),
        .pwr_state(pwr_state), .row_block(row_block), .col_block(col_block)
    );

    typedef struct {
        int    at;
        int    st;
        logic  rb;
        logic  cb;
        string tag;
    } exp_t;
    exp_t sb[$];

    task automatic expect_at(int at, int st, logic rb, logic cb, string tag);
        exp_t e;
        e.at = at; e.st = st; e.rb = rb; e.cb = cb; e.tag = tag;
        sb.push_back(e);
    endtask

    // monitor: compares queued expectations when their cycle comes up
    always @(negedge clk) begin : monitor
        exp_t e;
        #1;
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            e = sb.pop_front();
            checks++;
            if (e.at != cyc || int'(pwr_state) != e.st || row_block !== e.rb || col_block !== e.cb) begin
                errs++;
                $display("FAIL %s: cycle %0d state=%0d row=%0b col=%0b expected cycle %0d state=%0d row=%0b col=%0b",
                         e.tag, cyc, pwr_state, row_block, col_block, e.at, e.st, e.rb, e.cb);
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_until(int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic enter(logic pdn, logic a, logic rlx, output int e);
        @(negedge clk);
        pdn_enter = pdn; nap_enter = ~pdn; enter_sub_a = a; relax_in = rlx;
        e = cyc + 1;
        @(negedge clk);
        pdn_enter = 1'b0; nap_enter = 1'b0; enter_sub_a = 1'b0; relax_in = 1'b0;
    endtask

    task automatic send_frame(logic code, logic [5:0] id, output int k);
        @(negedge clk);
        cmd = 1'b1; sio_in = 1'b0;
        k = cyc + 1;
        @(negedge clk);
        cmd = code;
        if (cfg_slot) begin
            @(negedge clk);
            cmd = 1'b0;
        end
        if (!cfg_bcast)
            for (int i = 5; i >= 0; i--) begin
                @(negedge clk);
                cmd = 1'b0; sio_in = id[i];
            end
        @(negedge clk);
        cmd = 1'b0; sio_in = 1'b0;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin : driver
        int e, k;
        logic prev;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 state", int'(pwr_state), 0);
        chk("R1 row", int'(row_block), 0);
        chk("R1 col", int'(col_block), 0);
        chk("R1 sio_out", int'(sio_out), 0);

        // R2 nap entry; relax low
        enter(1'b0, 1'b0, 1'b0, e);
        expect_at(e, 2, 1'b0, 1'b0, "R2 nap entry");

        // R10 start on last lockout cycle is ignored
        wait_until(e + LOCK - 2);
        send_frame(1'b0, MY_ID, k);
        chk("R10 start edge", k, e + LOCK);
        expect_at(k + 9, 2, 1'b0, 1'b0, "R10 lockout start ignored");
        expect_at(k + 12, 2, 1'b0, 1'b0, "R10 lockout still nap");

        // R5 wrong identifier ignored
        wait_until(k + 12);
        send_frame(1'b0, 6'h2A, k);
        expect_at(k + 9, 2, 1'b0, 1'b0, "R5 id mismatch ignored");
        expect_at(k + 11, 2, 1'b0, 1'b0, "R5 id mismatch hold");

        // R6 power-down code while in nap ignored
        wait_until(k + 11);
        send_frame(1'b1, MY_ID, k);
        expect_at(k + 9, 2, 1'b0, 1'b0, "R6 wrong code ignored");
        expect_at(k + 11, 2, 1'b0, 1'b0, "R6 wrong code hold");

        // R3 entry pulse in low power ignored (relax=1 must not be kept)
        wait_until(k + 11);
        enter(1'b1, 1'b1, 1'b1, e);
        expect_at(e, 2, 1'b0, 1'b0, "R3 entry ignored in nap");
        expect_at(e + 1, 2, 1'b0, 1'b0, "R3 entry ignored hold");

        // R4 R7 R9 R8 addressed nap exit, delay 3
        wait_until(e + 1);
        send_frame(1'b0, MY_ID, k);
        expect_at(k + 9, 6, 1'b1, 1'b0, "R4 exit after id bits");
        expect_at(k + 12, 6, 1'b1, 1'b0, "R7 nap delay last cycle");
        expect_at(k + 13, 0, 1'b0, 1'b0, "R8 return to standby");

        // R2 power-down A with relax; R5 broadcast with any id
        wait_until(k + 14);
        enter(1'b1, 1'b1, 1'b1, e);
        expect_at(e, 5, 1'b0, 1'b0, "R2 pdn-A entry");
        cfg_bcast = 1'b1;
        wait_until(e + LOCK);
        send_frame(1'b1, 6'h00, k);
        expect_at(k + 3, 6, 1'b1, 1'b1, "R5 broadcast accepted");
        expect_at(k + 3 + 512, 6, 1'b1, 1'b1, "R7 pdn delay last cycle R9");
        expect_at(k + 516, 1, 1'b0, 1'b0, "R8 return to attention");
        wait_until(k + 517);
        cfg_bcast = 1'b0;

        // R12 entry and start bit in the same cycle
        @(negedge clk);
        nap_enter = 1'b1; relax_in = 1'b0; cmd = 1'b1;
        e = cyc + 1;
        @(negedge clk);
        nap_enter = 1'b0; cmd = 1'b0;
        expect_at(e, 2, 1'b0, 1'b0, "R12 entry wins");
        expect_at(e + 12, 2, 1'b0, 1'b0, "R12 start bit ignored");

        // R10 first free cycle accepted; R4 slot 0; R7 zero delay
        cfg_slot = 1'b0;
        cfg_nap_dly = 5'd0;
        wait_until(e + LOCK - 1);
        send_frame(1'b0, MY_ID, k);
        chk("R10 free start edge", k, e + LOCK + 1);
        expect_at(k + 8, 6, 1'b1, 1'b0, "R10 R4 exit slot0");
        expect_at(k + 9, 0, 1'b0, 1'b0, "R7 zero delay to standby");
        wait_until(k + 10);

        // R11 chain repeat
        prev = 1'b0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            if (i > 0) chk("R11 sio_out", int'(sio_out), int'(prev));
            sio_in = ((i * 5) % 3) == 1;
            prev = sio_in;
        end
        @(negedge clk);
        chk("R11 sio_out last", int'(sio_out), int'(prev));

        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            errs++;
            checks++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", sb.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule